// File: doc/BRIEF.md
# Flash command sequencer with ready/busy

This block is the control state machine of a small parallel NOR-style flash device. It watches host write cycles for a two-cycle unlock pattern followed by a command byte, starts a timed program or sector erase on a register-based array stub, and reports progress on an open-drain ready/busy line and through status bits returned in reads. An erase can be suspended so that other sectors can be read, then resumed.

A hardware reset pin is filtered for a minimum low time. A long enough pulse aborts any operation and returns the sequencer to read mode, and a recovery window follows before host cycles are accepted again. The host bus is synchronous: one clock with a write strobe or read strobe is one bus cycle, and read data is registered. A mode input selects 16-bit words or 8-bit bytes. In byte mode the top data bit carries the lowest address bit.

Top module: `flash_cmd_seq`

## Requirements
- R1: After power-up reset (por_n low) the block is in read mode: rdy_pulldown is 0, dq_oe is 0, and a read strobe sampled at a clock edge returns array data (all words 0xFFFF at power-up) on dq_out from that edge, with dq_oe at 0xFFFF in word mode, for one cycle.
- R2: Program is four writes: 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then data at the target. rdy_pulldown rises at the edge of the fourth write and stays 1 for exactly PROG_CYC cycles; the word then holds old AND data.
- R3: Sector erase is six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30 at any address in the sector (sector = top two bits of the 6-bit array index). rdy_pulldown stays 0 after the fifth write, rises at the edge of the sixth, and stays 1 for ERASE_CYC cycles when not suspended; the sector then reads 0xFFFF and other sectors are unchanged.
- R4: Any write that does not match the expected cycle of a sequence returns the sequencer to read mode with the array unchanged; command bytes and unlock data are compared on dq_in[7:0] only.
- R5: While rdy_pulldown reports busy for a program, further command sequences start nothing and change no array word.
- R6: While a program or erase runs (not suspended), every read returns a status word in which bit 6 inverts relative to the previous read; once the operation ends, reads return array data again.
- R7: Reads of the sector being erased, while erasing or suspended, return status with bit 2 inverting on each such read; reads of other sectors leave bit 2 unchanged.
- R8: Writing 0xB0 during an erase suspends it and releases rdy_pulldown; reads of other sectors return array data; writing 0x30 resumes the erase and reasserts rdy_pulldown.
- R9: While hw_reset_n is sampled low, dq_oe is 0 on the next cycle and rdy_pulldown is 1; reads and writes are ignored.
- R10: A low pulse on hw_reset_n of at least RST_MIN_CYC sampled edges aborts any operation (an aborted erase leaves the array unchanged) and returns to read mode; a pulse of RST_MIN_CYC-1 edges aborts nothing.
- R11: After a recognized reset is released, host cycles are ignored at the release edge and the following RECOV_CYC edges; a read at the next edge is accepted.
- R12: In byte mode (word_mode 0) dq_in[15] is the lowest address bit: it selects the upper byte when 1. Reads return that byte on dq_out[7:0] with dq_out[15:8] zero and dq_oe 0x00FF; a program write clears bits only in the selected byte using dq_in[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| hw_reset_n | input | 1 | Hardware reset pin, active low, width-filtered |
| word_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data; bit 15 is the low address bit in byte mode |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 16 | Per-bit output enable for dq_out |
| rdy_pulldown | output | 1 | Open-drain ready/busy: 1 pulls the shared line low (busy) |

## Verification
The bench builds the block with PROG_CYC 6, ERASE_CYC 24, RST_MIN_CYC 8 and RECOV_CYC 4, so that exact busy lengths, the full reset pulse and the one-edge boundaries of the recovery window are each a few dozen cycles. With a short erase the suspend, status reads and resume all fit inside one erase, and a reset pulse of RST_MIN_CYC-1 edges can overlap a running program and be shown to abort nothing.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ   = 4'd0,
        ST_UNL1   = 4'd1,
        ST_UNL2   = 4'd2,
        ST_PDATA  = 4'd3,
        ST_EUNL1  = 4'd4,
        ST_EUNL2  = 4'd5,
        ST_ECMD   = 4'd6,
        ST_PROG   = 4'd7,
        ST_ERASE  = 4'd8,
        ST_SUSP   = 4'd9
    } seq_state_e;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE_SU = 8'h80;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_SUSPEND  = 8'hB0;
    localparam logic [7:0] OP_RESUME   = 8'h30;

    localparam int unsigned KEY_ADDR_A = 'h555;
    localparam int unsigned KEY_ADDR_B = 'h2AA;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code_in,
    output logic              at_key_a,
    output logic              at_key_b,
    output logic              key1_hit,
    output logic              key2_hit,
    output logic [7:0]        code
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(KEY_ADDR_B);

    always_comb begin
        code     = code_in;
        at_key_a = (addr == KEY_A);
        at_key_b = (addr == KEY_B);
        key1_hit = at_key_a && (code_in == KEY_FIRST);
        key2_hit = at_key_b && (code_in == KEY_SECOND);
    end
endmodule

// File: rtl/flash_rst_filter.sv
module flash_rst_filter #(
    parameter int MIN_CYC   = 125,
    parameter int RECOV_CYC = 13
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic abort,
    output logic blocked
);
    localparam int LOW_W = $clog2(MIN_CYC + 1);
    localparam int REC_W = $clog2(RECOV_CYC + 1);

    logic [LOW_W-1:0] low_d, low_q;
    logic [REC_W-1:0] rec_d, rec_q;
    logic             armed_d, armed_q;

    always_comb begin
        low_d   = low_q;
        rec_d   = rec_q;
        armed_d = armed_q;
        abort   = 1'b0;
        if (!pin_n) begin
            rec_d = '0;
            if (low_q != LOW_W'(MIN_CYC)) begin
                low_d = low_q + 1'b1;
            end
            if (low_q == LOW_W'(MIN_CYC - 1)) begin
                abort   = 1'b1;
                armed_d = 1'b1;
            end
        end else begin
            low_d = '0;
            if (armed_q) begin
                armed_d = 1'b0;
                rec_d   = REC_W'(RECOV_CYC);
            end else if (rec_q != '0) begin
                rec_d = rec_q - 1'b1;
            end
        end
    end

    assign blocked = !pin_n || armed_q || (rec_q != '0);

    always_ff @(posedge clk) begin
        if (!por_n) begin
            low_q   <= '0;
            rec_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            low_q   <= low_d;
            rec_q   <= rec_d;
            armed_q <= armed_d;
        end
    end

    // R10: an abort needs the pin low now and on the edge before (MIN_CYC >= 2)
    a_r10_abort_needs_width: assert property (@(posedge clk) disable iff (!por_n)
        abort |-> (!pin_n && $past(!pin_n)));

    // R11: releasing a recognized reset opens the recovery window
    a_r11_release_blocks: assert property (@(posedge clk) disable iff (!por_n)
        (armed_q && pin_n) |=> blocked);
endmodule

// File: rtl/flash_array_stub.sv
module flash_array_stub #(
    parameter int ARR_AW = 6,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ARR_AW-1:0] rd_idx,
    output logic [15:0]       rd_data,
    input  logic              prog_en,
    input  logic [ARR_AW-1:0] prog_idx,
    input  logic [15:0]       prog_data,
    input  logic [1:0]        prog_lane,
    input  logic              erase_en,
    input  logic [SECT_W-1:0] erase_sect
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [15:0] mem_d [DEPTH];
    logic [15:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_en && (SECT_W'(i >> (ARR_AW - SECT_W)) == erase_sect)) begin
                mem_d[i] = 16'hFFFF;
            end
        end
        if (prog_en) begin
            if (prog_lane[0]) mem_d[prog_idx][7:0]  = mem_q[prog_idx][7:0]  & prog_data[7:0];
            if (prog_lane[1]) mem_d[prog_idx][15:8] = mem_q[prog_idx][15:8] & prog_data[15:8];
        end
    end

    assign rd_data = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!por_n) mem_q[i] <= 16'hFFFF;
            else        mem_q[i] <= mem_d[i];
        end
    end

    // R3: program and erase never commit in the same cycle
    a_r3_one_commit: assert property (@(posedge clk) disable iff (!por_n)
        !(prog_en && erase_en));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int ARR_AW      = 6,
    parameter int SECT_W      = 2,
    parameter int PROG_CYC    = 16,
    parameter int ERASE_CYC   = 256,
    parameter int RST_MIN_CYC = 125,
    parameter int RECOV_CYC   = 13
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_reset_n,
    input  logic              word_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              rdy_pulldown
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              tog6;
        logic              tog2;
        logic [SECT_W-1:0] esect;
        logic [ARR_AW-1:0] paddr;
        logic [15:0]       pdata;
        logic [1:0]        plane;
        logic [15:0]       dq_out;
        logic [15:0]       dq_oe;
        logic              busy;
    } seq_t;

    seq_t q, d;

    logic              abort, blocked, wr_ok, rd_ok;
    logic              at_key_a, at_key_b, key1_hit, key2_hit;
    logic [7:0]        code;
    logic [15:0]       arr_rdata;
    logic              prog_en, erase_en;
    logic [ARR_AW-1:0] arr_idx;
    logic [SECT_W-1:0] arr_sect;
    logic              a_low;
    logic              running, in_esect;

    flash_rst_filter #(.MIN_CYC(RST_MIN_CYC), .RECOV_CYC(RECOV_CYC)) u_rst (
        .clk     (clk),
        .por_n   (por_n),
        .pin_n   (hw_reset_n),
        .abort   (abort),
        .blocked (blocked)
    );

    flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (addr),
        .code_in  (dq_in[7:0]),
        .at_key_a (at_key_a),
        .at_key_b (at_key_b),
        .key1_hit (key1_hit),
        .key2_hit (key2_hit),
        .code     (code)
    );

    flash_array_stub #(.ARR_AW(ARR_AW), .SECT_W(SECT_W)) u_arr (
        .clk        (clk),
        .por_n      (por_n),
        .rd_idx     (arr_idx),
        .rd_data    (arr_rdata),
        .prog_en    (prog_en),
        .prog_idx   (q.paddr),
        .prog_data  (q.pdata),
        .prog_lane  (q.plane),
        .erase_en   (erase_en),
        .erase_sect (q.esect)
    );

    assign wr_ok    = wr_en && !blocked;
    assign rd_ok    = rd_en && !blocked;
    assign arr_idx  = addr[ARR_AW-1:0];
    assign arr_sect = addr[ARR_AW-1 -: SECT_W];
    assign a_low    = !word_mode && dq_in[15];
    assign running  = (q.state == ST_PROG) || (q.state == ST_ERASE);
    assign in_esect = (arr_sect == q.esect);

    always_comb begin
        d        = q;
        d.dq_oe  = '0;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        if (abort) begin
            d.state = ST_READ;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                ST_READ: if (wr_ok && key1_hit) d.state = ST_UNL1;
                ST_UNL1: if (wr_ok) d.state = key2_hit ? ST_UNL2 : ST_READ;
                ST_UNL2: if (wr_ok) begin
                    if (at_key_a && code == OP_PROGRAM)       d.state = ST_PDATA;
                    else if (at_key_a && code == OP_ERASE_SU) d.state = ST_EUNL1;
                    else                                      d.state = ST_READ;
                end
                ST_PDATA: if (wr_ok) begin
                    d.state = ST_PROG;
                    d.cnt   = '0;
                    d.tog6  = 1'b0;
                    d.tog2  = 1'b0;
                    d.paddr = arr_idx;
                    d.pdata = word_mode ? dq_in : {dq_in[7:0], dq_in[7:0]};
                    d.plane = word_mode ? 2'b11 : (a_low ? 2'b10 : 2'b01);
                end
                ST_EUNL1: if (wr_ok) d.state = key1_hit ? ST_EUNL2 : ST_READ;
                ST_EUNL2: if (wr_ok) d.state = key2_hit ? ST_ECMD : ST_READ;
                ST_ECMD: if (wr_ok) begin
                    if (code == OP_SECTOR) begin
                        d.state = ST_ERASE;
                        d.cnt   = '0;
                        d.tog6  = 1'b0;
                        d.tog2  = 1'b0;
                        d.esect = arr_sect;
                    end else begin
                        d.state = ST_READ;
                    end
                end
                ST_PROG: begin
                    if (q.cnt == CNT_W'(PROG_CYC - 1)) begin
                        prog_en = 1'b1;
                        d.state = ST_READ;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (q.cnt == CNT_W'(ERASE_CYC - 1)) begin
                        erase_en = 1'b1;
                        d.state  = ST_READ;
                        d.cnt    = '0;
                    end else if (wr_ok && code == OP_SUSPEND) begin
                        d.state = ST_SUSP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_SUSP: if (wr_ok && code == OP_RESUME) d.state = ST_ERASE;
                default: d.state = ST_READ;
            endcase

            if (rd_ok) begin
                if (running || (q.state == ST_SUSP && in_esect)) begin
                    d.dq_out = {8'h00, 1'b0, q.tog6, 3'b000, q.tog2, 2'b00};
                    if (running) d.tog6 = ~q.tog6;
                    if ((q.state == ST_ERASE || q.state == ST_SUSP) && in_esect) d.tog2 = ~q.tog2;
                end else if (word_mode) begin
                    d.dq_out = arr_rdata;
                end else begin
                    d.dq_out = {8'h00, a_low ? arr_rdata[15:8] : arr_rdata[7:0]};
                end
                d.dq_oe = word_mode ? 16'hFFFF : 16'h00FF;
            end
        end
        d.busy = (d.state == ST_PROG) || (d.state == ST_ERASE) || !hw_reset_n;
    end

    always_ff @(posedge clk) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign dq_out       = q.dq_out;
    assign dq_oe        = q.dq_oe;
    assign rdy_pulldown = q.busy;

    // R2: busy only appears after a write or a low reset pin
    a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rdy_pulldown) |-> ($past(wr_en) || $past(!hw_reset_n)));

    // R5: a running program can only finish or be aborted
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == ST_PROG) |=> (q.state == ST_PROG || q.state == ST_READ));

    // R8: a suspended erase reports ready
    a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == ST_SUSP && $past(hw_reset_n)) |-> !rdy_pulldown);

    // R9: low reset pin silences the data bus and shows busy
    a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        $past(!hw_reset_n) |-> (dq_oe == '0 && rdy_pulldown));
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int AW     = 11;
    localparam int PCYC   = 6;
    localparam int ECYC   = 24;
    localparam int RMIN   = 8;
    localparam int RREC   = 4;
    localparam int NVEC   = 34;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          hw_reset_n = 1'b1;
    logic          word_mode = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out, dq_oe;
    logic          rdy_pulldown;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(AW), .ARR_AW(6), .SECT_W(2), .PROG_CYC(PCYC),
        .ERASE_CYC(ECYC), .RST_MIN_CYC(RMIN), .RECOV_CYC(RREC)
    ) i_flash_cmd_seq (
        .clk(clk), .por_n(por_n), .hw_reset_n(hw_reset_n), .word_mode(word_mode),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .rdy_pulldown(rdy_pulldown)
    );

    // op: 0 write, 1 read and compare, 2 wait for ready
    localparam logic [44:0] VECS [NVEC] = '{
        {2'd0, 11'h555, 16'h00AA, 16'h0000},   // R4 bad command byte
        {2'd0, 11'h2AA, 16'h0055, 16'h0000},
        {2'd0, 11'h555, 16'h0077, 16'h0000},
        {2'd0, 11'h003, 16'h1234, 16'h0000},
        {2'd1, 11'h003, 16'h0000, 16'hFFFF},
        {2'd0, 11'h555, 16'h00AA, 16'h0000},   // R2 program
        {2'd0, 11'h2AA, 16'h0055, 16'h0000},
        {2'd0, 11'h555, 16'h00A0, 16'h0000},
        {2'd0, 11'h003, 16'h1234, 16'h0000},
        {2'd2, 11'h000, 16'h0000, 16'h0000},
        {2'd1, 11'h003, 16'h0000, 16'h1234},
        {2'd0, 11'h555, 16'h00AA, 16'h0000},   // R2 AND with old
        {2'd0, 11'h2AA, 16'h0055, 16'h0000},
        {2'd0, 11'h555, 16'h00A0, 16'h0000},
        {2'd0, 11'h003, 16'hFF0F, 16'h0000},
        {2'd2, 11'h000, 16'h0000, 16'h0000},
        {2'd1, 11'h003, 16'h0000, 16'h1204},
        {2'd0, 11'h555, 16'h00AA, 16'h0000},   // R4 bad second unlock
        {2'd0, 11'h2AA, 16'h0000, 16'h0000},
        {2'd0, 11'h555, 16'h00A0, 16'h0000},
        {2'd0, 11'h004, 16'h0000, 16'h0000},
        {2'd1, 11'h004, 16'h0000, 16'hFFFF},
        {2'd0, 11'h555, 16'hFFAA, 16'h0000},   // R4 upper bits ignored
        {2'd0, 11'h2AA, 16'h3355, 16'h0000},
        {2'd0, 11'h555, 16'h00A0, 16'h0000},
        {2'd0, 11'h010, 16'h5A5A, 16'h0000},
        {2'd2, 11'h000, 16'h0000, 16'h0000},
        {2'd1, 11'h010, 16'h0000, 16'h5A5A},
        {2'd0, 11'h555, 16'h00AA, 16'h0000},
        {2'd0, 11'h2AA, 16'h0055, 16'h0000},
        {2'd0, 11'h555, 16'h00A0, 16'h0000},
        {2'd0, 11'h020, 16'hC3C3, 16'h0000},
        {2'd2, 11'h000, 16'h0000, 16'h0000},
        {2'd1, 11'h020, 16'h0000, 16'hC3C3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        addr = a; dq_in = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] d, output logic [15:0] r);
        addr = a; dq_in = d; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        r = dq_out;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (rdy_pulldown && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic prog_cmd(input logic [AW-1:0] a, input logic [15:0] d);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
    endtask

    task automatic erase_cmd(input logic [AW-1:0] a);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, 16'h0030);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r1, r2;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state and read latency
        chk("R1 busy", rdy_pulldown, 0);
        chk("R1 oe", dq_oe, 0);
        rd(11'h000, 16'h0, r1);
        chk("R1 data", r1, 16'hFFFF);
        chk("R1 oe word", dq_oe, 16'hFFFF);
        @(negedge clk);
        chk("R1 oe one cycle", dq_oe, 0);

        // table walk: R2 and R4
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [10:0] va;
            logic [15:0] vd, ve;
            {op, va, vd, ve} = VECS[i];
            if (op == 2'd0) wr(va, vd);
            else if (op == 2'd1) begin
                rd(va, 16'h0, r1);
                chk($sformatf("R2/R4 vector %0d", i), r1, ve);
            end else wait_ready(n);
        end

        // R2 exact busy length
        prog_cmd(11'h007, 16'h00FF);
        wait_ready(n);
        chk("R2 busy cycles", n, PCYC);

        // R6 toggle and R5 ignored commands
        prog_cmd(11'h005, 16'h0F0F);
        rd(11'h005, 16'h0, r1);
        rd(11'h005, 16'h0, r2);
        chk("R6 dq6 toggles", r1 ^ r2, 16'h0040);
        prog_cmd(11'h006, 16'h0000);
        wait_ready(n);
        rd(11'h006, 16'h0, r1);
        chk("R5 ignored program", r1, 16'hFFFF);
        rd(11'h005, 16'h0, r1);
        rd(11'h005, 16'h0, r2);
        chk("R6 data after ready", r1, 16'h0F0F);
        chk("R6 no toggle after ready", r2, 16'h0F0F);

        // R3, R7, R8 erase with suspend
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
        chk("R3 not busy after fifth", rdy_pulldown, 0);
        wr(11'h013, 16'h0030);
        chk("R3 busy after sixth", rdy_pulldown, 1);
        rd(11'h010, 16'h0, r1);
        rd(11'h012, 16'h0, r2);
        chk("R7 erasing sector status", r1 ^ r2, 16'h0044);
        rd(11'h030, 16'h0, r1);
        rd(11'h031, 16'h0, r2);
        chk("R7 other sector no dq2", r1 ^ r2, 16'h0040);
        wr(11'h000, 16'h00B0);
        chk("R8 suspend ready", rdy_pulldown, 0);
        rd(11'h020, 16'h0, r1);
        chk("R8 other sector data", r1, 16'hC3C3);
        rd(11'h010, 16'h0, r1);
        rd(11'h010, 16'h0, r2);
        chk("R7 suspended sector dq2", r1 ^ r2, 16'h0004);
        wr(11'h000, 16'h0030);
        chk("R8 resume busy", rdy_pulldown, 1);
        wait_ready(n);
        rd(11'h010, 16'h0, r1);
        chk("R3 sector erased", r1, 16'hFFFF);
        rd(11'h01F, 16'h0, r1);
        chk("R3 sector end erased", r1, 16'hFFFF);
        rd(11'h020, 16'h0, r1);
        chk("R3 other sector kept", r1, 16'hC3C3);
        erase_cmd(11'h030);
        wait_ready(n);
        chk("R3 erase cycles", n, ECYC);

        // R12 byte mode
        word_mode = 1'b0;
        wr(11'h555, 16'h7EAA); wr(11'h2AA, 16'h0155); wr(11'h555, 16'h33A0);
        wr(11'h008, 16'h803C);
        wait_ready(n);
        rd(11'h008, 16'h8000, r1);
        chk("R12 high byte", r1, 16'h003C);
        chk("R12 oe byte", dq_oe, 16'h00FF);
        rd(11'h008, 16'h0000, r1);
        chk("R12 low byte", r1, 16'h00FF);
        word_mode = 1'b1;
        rd(11'h008, 16'h0, r1);
        chk("R12 word view", r1, 16'h3CFF);

        // R9 and R10 short pulse during program
        prog_cmd(11'h009, 16'h1111);
        hw_reset_n = 1'b0;
        rd(11'h009, 16'h0, r1);
        chk("R9 oe low in reset", dq_oe, 0);
        chk("R9 busy in reset", rdy_pulldown, 1);
        repeat (RMIN - 2) @(negedge clk);
        hw_reset_n = 1'b1;
        @(negedge clk);
        wait_ready(n);
        rd(11'h009, 16'h0, r1);
        chk("R10 short pulse ignored", r1, 16'h1111);

        // R10 and R11 long pulse during erase
        erase_cmd(11'h020);
        hw_reset_n = 1'b0;
        rd(11'h020, 16'h0, r1);
        chk("R9 oe low long reset", dq_oe, 0);
        repeat (RMIN - 1) @(negedge clk);
        hw_reset_n = 1'b1;
        repeat (RREC) @(negedge clk);
        rd(11'h020, 16'h0, r1);
        chk("R11 read in recovery ignored", dq_oe, 0);
        rd(11'h020, 16'h0, r1);
        chk("R11 read after recovery", dq_oe, 16'hFFFF);
        chk("R10 aborted erase kept data", r1, 16'hC3C3);
        chk("R10 ready after abort", rdy_pulldown, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule